// File: doc/BRIEF.md
# Latched Headphone Short-Detect Monitor

This block turns the raw outputs of the headphone drivers' over-current comparators into two status bits that software or a power manager can read. There are two groups. The stereo group merges the left and right comparators into one status. The center group watches the single comparator of the common driver. Each group has its own 2-bit mode field. The mode picks one of three behaviours: a transparent view of the comparator, a latch that clears itself when a timeout expires, or a latch that holds until software clears it.

The comparator inputs are asynchronous to the block clock, so each passes through a two-flop synchroniser first. The timeout counts pulses on a `tick` input. The default count approximates a 50 ms period from a 1 MHz tick. The count starts again whenever a group's mode field changes. In the self-clearing mode, a short that is still present when the timeout fires sets the latch again on the following cycle. The status therefore dips low for exactly one cycle.

Top module: `short_watch`

## Requirements
- R1: A comparator edge reaches a transparent-mode status output after exactly two rising clock edges, through the two synchroniser flops.
- R2: Mode value 0 shows the synchronised comparator directly on the status, and it clears that group's latch.
- R3: Mode value 2 behaves exactly like mode value 0.
- R4: With mode value 1, the status stays high after a short until the group has counted TIMEOUT_TICKS `tick` pulses in that mode. The status is low on the cycle after the last of those pulses. The status can only fall after a cycle with `tick` high.
- R5: With mode value 1 and a short still present at the timeout, the status is low for exactly one cycle and then high again.
- R6: With mode value 3, the status stays high after a short whatever `tick` does. Only a change to mode value 0 or 2 clears it.
- R7: The stereo status is the OR of the left and right comparators. The center status depends only on the center comparator.
- R8: Any cycle in which a group's mode field differs from its value in the previous cycle restarts that group's timeout count from zero. A `tick` in that cycle is not counted.
- R9: While `rst_n` is low, both status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_left | input | 1 | Left driver over-current comparator (asynchronous) |
| cmp_right | input | 1 | Right driver over-current comparator (asynchronous) |
| cmp_center | input | 1 | Center driver over-current comparator (asynchronous) |
| mode_lr | input | 2 | Stereo group mode: 0 transparent, 1 self-clearing latch, 2 as 0, 3 held latch |
| mode_ctr | input | 2 | Center group mode, same encoding as `mode_lr` |
| tick | input | 1 | Timebase pulse that advances the timeout counters |
| flag_lr | output | 1 | Stereo short status |
| flag_ctr | output | 1 | Center short status |

## Verification
Directed tests cover several cases:
- Single-cycle comparator pulses in each mode. Latching is separated from transparency by what the status does after the pulse ends.
- Left-only, right-only and center-only shorts. These show the OR merge and that the two groups do not affect each other.
- A short held through several timeouts in the self-clearing mode. This exposes the one-cycle dip.
- A count of one tick fewer than the limit on each side of a brief mode change. This shows whether the counter restarted.

Constrained random stimulus then mixes sparse shorts, irregular ticks and random mode changes, including the unused value 2, in both groups. It is compared every cycle against a bench model built from the requirements.

// File: rtl/short_watch_pkg.sv
package short_watch_pkg;

    typedef enum logic [1:0] {
        MODE_OPEN = 2'd0,
        MODE_AUTO = 2'd1,
        MODE_RSVD = 2'd2,
        MODE_HOLD = 2'd3
    } det_mode_e;

    // Modes that show the comparator directly and keep the latch clear
    function automatic logic mode_is_open(input logic [1:0] m);
        return (m == MODE_OPEN) || (m == MODE_RSVD);
    endfunction

endpackage

// File: rtl/short_watch_sync.sv
module short_watch_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[LAST];
endmodule

// File: rtl/short_watch_group.sv
module short_watch_group
    import short_watch_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       short_i,
    input  logic [1:0] mode_i,
    input  logic       tick_i,
    output logic       flag_o
);
    localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);

    typedef struct packed {
        logic             latch;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       mode_seen;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        st_d           = st_q;
        fire           = 1'b0;
        st_d.mode_seen = mode_i;
        if (mode_is_open(mode_i)) begin
            st_d.latch = 1'b0;
            st_d.cnt   = '0;
        end else begin
            if (mode_i != st_q.mode_seen) begin
                st_d.cnt = '0;
            end else if (mode_i == MODE_AUTO) begin
                if (tick_i) begin
                    if (st_q.cnt == CNT_LAST) begin
                        fire     = 1'b1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end else begin
                st_d.cnt = '0;
            end
            st_d.latch = fire ? 1'b0 : (st_q.latch | short_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = mode_is_open(mode_i) ? short_i : st_q.latch;
endmodule

// File: rtl/short_watch.sv
module short_watch #(
    parameter int TIMEOUT_TICKS = 50000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_left,
    input  logic       cmp_right,
    input  logic       cmp_center,
    input  logic [1:0] mode_lr,
    input  logic [1:0] mode_ctr,
    input  logic       tick,
    output logic       flag_lr,
    output logic       flag_ctr
);
    localparam int NUM_CMP    = 3;
    localparam int NUM_GROUPS = 2;

    logic [NUM_CMP-1:0]         cmp_sync;
    logic [NUM_GROUPS-1:0]      grp_short;
    logic [NUM_GROUPS-1:0][1:0] grp_mode;
    logic [NUM_GROUPS-1:0]      grp_flag;

    short_watch_sync #(
        .WIDTH  (NUM_CMP),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cmp_center, cmp_right, cmp_left}),
        .sync_o  (cmp_sync)
    );

    // group 0: stereo pair merged, group 1: center driver
    assign grp_short = {cmp_sync[2], cmp_sync[0] | cmp_sync[1]};
    assign grp_mode  = {mode_ctr, mode_lr};

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        short_watch_group #(
            .TIMEOUT_TICKS (TIMEOUT_TICKS)
        ) i_group (
            .clk     (clk),
            .rst_n   (rst_n),
            .short_i (grp_short[g]),
            .mode_i  (grp_mode[g]),
            .tick_i  (tick),
            .flag_o  (grp_flag[g])
        );
    end

    assign flag_lr  = grp_flag[0];
    assign flag_ctr = grp_flag[1];
endmodule

// File: rtl/short_watch_chk.sv
module short_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmp_left,
    input logic       cmp_right,
    input logic       cmp_center,
    input logic [1:0] mode_lr,
    input logic [1:0] mode_ctr,
    input logic       tick,
    input logic       flag_lr,
    input logic       flag_ctr
);
    logic [1:0] edges_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges_q <= '0;
        end else if (edges_q != 2'd2) begin
            edges_q <= edges_q + 2'd1;
        end
    end
    assign warm = (edges_q == 2'd2);

    // R2 and R7: transparent stereo status follows OR of both comparators two edges back
    assert_mode0_lr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && mode_lr == 2'd0) |-> (flag_lr == ($past(cmp_left, 2) | $past(cmp_right, 2))));

    // R3: reserved mode is transparent on the center group
    assert_mode2_ctr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && mode_ctr == 2'd2) |-> (flag_ctr == $past(cmp_center, 2)));

    // R6: held latch never drops while mode stays 3
    assert_hold_lr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lr == 2'd3 && flag_lr) |=> (mode_lr != 2'd3 || flag_lr));

    assert_hold_ctr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ctr == 2'd3 && flag_ctr) |=> (mode_ctr != 2'd3 || flag_ctr));

    // R4: in self-clearing mode the status only falls after a tick
    assert_fall_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lr == 2'd1 && flag_lr && !tick) |=> (mode_lr != 2'd1 || flag_lr));
endmodule

bind short_watch short_watch_chk i_short_watch_chk (.*);

// File: tb/test_short_watch.sv
`timescale 1ns/1ps
module test_short_watch;
    localparam int TO = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_left = 1'b0, cmp_right = 1'b0, cmp_center = 1'b0;
    logic [1:0] mode_lr = 2'd0, mode_ctr = 2'd0;
    logic       tick = 1'b0;
    logic       flag_lr, flag_ctr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    short_watch #(.TIMEOUT_TICKS(TO)) i_short_watch (
        .clk, .rst_n, .cmp_left, .cmp_right, .cmp_center,
        .mode_lr, .mode_ctr, .tick, .flag_lr, .flag_ctr
    );

    // reference model from the requirements
    logic [2:0] m_s1 = '0, m_s2 = '0;
    logic       m_lat [2];
    int         m_cnt [2];
    logic [1:0] m_prev [2];

    function automatic logic is_open(input logic [1:0] m);
        return (m == 2'd0) || (m == 2'd2);
    endfunction

    function automatic logic grp_short(input int g, input logic [2:0] s);
        return (g == 0) ? (s[0] | s[1]) : s[2];
    endfunction

    function automatic logic model_flag(input int g, input logic [1:0] md);
        return is_open(md) ? grp_short(g, m_s2) : m_lat[g];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0;
            for (int g = 0; g < 2; g++) begin
                m_lat[g] = 1'b0; m_cnt[g] = 0; m_prev[g] = 2'd0;
            end
        end else begin
            for (int g = 0; g < 2; g++) begin
                logic [1:0] md;
                logic       fire;
                md   = (g == 0) ? mode_lr : mode_ctr;
                fire = 1'b0;
                if (is_open(md)) begin
                    m_lat[g] = 1'b0; m_cnt[g] = 0;
                end else begin
                    if (md != m_prev[g]) m_cnt[g] = 0;
                    else if (md == 2'd1 && tick) begin
                        if (m_cnt[g] == TO - 1) begin fire = 1'b1; m_cnt[g] = 0; end
                        else m_cnt[g] = m_cnt[g] + 1;
                    end
                    m_lat[g] = fire ? 1'b0 : (m_lat[g] | grp_short(g, m_s2));
                end
                m_prev[g] = md;
            end
            m_s2 = m_s1;
            m_s1 = {cmp_center, cmp_right, cmp_left};
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0: return "R2";
            2'd1: return "R4";
            2'd2: return "R3";
            default: return "R6";
        endcase
    endfunction

    // advance to the next falling edge and compare both groups with the model
    task automatic step();
        @(negedge clk);
        chk({mode_req(mode_lr), " stereo model"}, flag_lr, model_flag(0, mode_lr));
        chk({mode_req(mode_ctr), " center model"}, flag_ctr, model_flag(1, mode_ctr));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        int dips;
        logic prev_low;
        void'($urandom(32'h5eed_0017));
        repeat (4) @(negedge clk);
        chk("R9 reset stereo", flag_lr, 1'b0);
        chk("R9 reset center", flag_ctr, 1'b0);
        rst_n = 1'b1;
        step();

        // R1: two-edge latency in transparent mode
        cmp_left = 1'b1;
        step(); chk("R1 after one edge", flag_lr, 1'b0);
        step(); chk("R1 after two edges", flag_lr, 1'b1);
        cmp_left = 1'b0;
        step(); step(); chk("R2 transparent release", flag_lr, 1'b0);

        // R7: right alone drives stereo, center is independent
        cmp_right = 1'b1;
        step(); step();
        chk("R7 right sets stereo", flag_lr, 1'b1);
        chk("R7 center untouched", flag_ctr, 1'b0);
        cmp_right = 1'b0; cmp_center = 1'b1;
        step(); step();
        chk("R7 center own status", flag_ctr, 1'b1);
        chk("R7 stereo clear", flag_lr, 1'b0);
        cmp_center = 1'b0;
        step(); step();

        // R3: mode 2 is transparent
        mode_ctr = 2'd2; cmp_center = 1'b1;
        step(); cmp_center = 1'b0;
        step(); chk("R3 pulse seen", flag_ctr, 1'b1);
        step(); chk("R3 no latch", flag_ctr, 1'b0);
        mode_ctr = 2'd0;

        // R6: held latch ignores ticks, cleared by mode 0
        mode_lr = 2'd3; tick = 1'b1;
        step(); cmp_left = 1'b1;
        step(); cmp_left = 1'b0;
        repeat (4 * TO) step();
        chk("R6 held through ticks", flag_lr, 1'b1);
        mode_lr = 2'd0;
        step(); chk("R6 mode 0 clears", flag_lr, 1'b0);
        mode_lr = 2'd3;
        step(); step(); chk("R2 latch was cleared", flag_lr, 1'b0);

        // R4 and R8: counter restarts on a mode change
        mode_lr = 2'd1; tick = 1'b0;
        step(); cmp_left = 1'b1;
        step(); cmp_left = 1'b0;
        repeat (3) step();
        chk("R4 latched", flag_lr, 1'b1);
        tick = 1'b1;
        repeat (TO - 1) step();
        tick = 1'b0;
        mode_lr = 2'd3; step();
        mode_lr = 2'd1; step();
        tick = 1'b1;
        repeat (TO - 1) step();
        tick = 1'b0;
        step(); chk("R8 count restarted", flag_lr, 1'b1);
        tick = 1'b1;
        step(); tick = 1'b0;
        chk("R4 timeout clears", flag_lr, 1'b0);
        step(); chk("R4 stays clear", flag_lr, 1'b0);

        // R5: persistent short re-latches after each timeout
        cmp_left = 1'b1; tick = 1'b1;
        repeat (4) step();
        dips = 0; prev_low = 1'b0;
        repeat (4 * TO) begin
            step();
            if (prev_low) chk("R5 dip is one cycle", flag_lr, 1'b1);
            prev_low = !flag_lr;
            if (!flag_lr) dips++;
        end
        chk("R5 dips observed", dips > 0, 1'b1);
        cmp_left = 1'b0; tick = 1'b0; mode_lr = 2'd0;
        repeat (3) step();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            cmp_left   = ($urandom_range(15) == 0);
            cmp_right  = ($urandom_range(15) == 0);
            cmp_center = ($urandom_range(11) == 0);
            tick       = ($urandom_range(2) == 0);
            if ($urandom_range(39) == 0) mode_lr  = 2'($urandom_range(3));
            if ($urandom_range(39) == 0) mode_ctr = 2'($urandom_range(3));
            step();
        end

        finish_run();
    end
endmodule